// File: doc/BRIEF.md
# Carry-Skip Shift Accumulator

This block closes a bit-serial multiply-accumulate datapath. A preceding adder tree delivers one partial sum per clock. The block folds that partial sum into a running total. Each earlier partial sum carries twice the weight of the one after it, so the total is doubled before every addition. After a frame of `FRAME_LEN` partial sums, the finished total is published as one result.

The running-total adder is a carry-skip design. It is split into 4-bit groups, and each group is a ripple chain of four full adders. When every bit pair in a group has exactly one 1, the group cannot generate or absorb a carry. In that case a bypass multiplexer passes the group's incoming carry straight on to the next group. This shortens the worst carry path through the accumulator.

A frame opens with a beat that has `frame_start` set. That beat loads its partial sum directly, so the frame needs no separate clear cycle. Beats that arrive while no frame is open are dropped. A new `frame_start` in the middle of a frame discards the partial frame.

Top module: `skip_shift_acc`

## Requirements
- R1: The adder returns `a + b + cin` for any operands, as a W-bit sum plus a carry-out, where W is a multiple of 4.
- R2: When every bit pair of a 4-bit group has exactly one 1, the carry leaving that group equals the carry entering it. For example, at 8 bits, 0x0F + 0x00 with carry-in 1 gives 0x10.
- R3: A beat with `in_valid`=1 and `frame_start`=1 starts a new frame. The running total becomes that beat's partial sum, and any earlier contents are discarded.
- R4: Each later beat of an open frame replaces the total T with 2·T + p. The first partial sum therefore ends with weight 2^(FRAME_LEN-1), and the last one ends with weight 1.
- R5: On the clock edge that absorbs the FRAME_LEN-th beat, `result_o` takes the frame total. On that same edge, `done_o` goes high for exactly one cycle.
- R6: `result_o` changes only on an edge that raises `done_o`. Otherwise it holds its value.
- R7: A cycle with `in_valid`=0 neither advances nor changes an open frame. A beat with `frame_start`=0 while no frame is open is ignored.
- R8: A `frame_start` beat in the middle of a frame abandons the partial frame. No result is produced for the abandoned frame.
- R9: The total is IN_W+FRAME_LEN bits wide and never overflows. A frame of all-ones partial sums gives (2^IN_W−1)·(2^FRAME_LEN−1).
- R10: While reset is held, `done_o` is 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A partial sum is present this cycle |
| frame_start | input | 1 | This beat opens a new frame |
| psum_i | input | IN_W | Unsigned partial sum from the adder tree |
| done_o | output | 1 | One-cycle strobe: a new result is on `result_o` |
| result_o | output | IN_W+FRAME_LEN | Total of the most recent completed frame |

## Verification
The adder is purely combinational, so its sum and carry are checked one time step after the operands are applied. It is checked exhaustively at 8 bits and with random operands at the full accumulator width. For the accumulator, the driver changes inputs just after a rising edge, and the FRAME_LEN-th beat is absorbed on the next rising edge. `done_o` and `result_o` are therefore due in the cycle that follows that edge. The monitor samples them on the falling edge of that cycle and compares them against the oldest item in the scoreboard queue. On every other falling edge, the monitor checks that `done_o` is low and that `result_o` has not moved since the previous sample.

// File: rtl/skip_acc_pkg.sv
package skip_acc_pkg;
    localparam int GROUP_W = 4;

    function automatic int round_up_groups(input int w);
        return ((w + GROUP_W - 1) / GROUP_W) * GROUP_W;
    endfunction
endpackage

// File: rtl/cskip_group.sv
module cskip_group
    import skip_acc_pkg::*;
(
    input  logic [GROUP_W-1:0] a,
    input  logic [GROUP_W-1:0] b,
    input  logic               ci,
    output logic [GROUP_W-1:0] s,
    output logic               co
);
    logic [GROUP_W-1:0] prop;
    logic [GROUP_W-1:0] gen;
    logic [GROUP_W:0]   chain;

    always_comb begin
        prop     = a ^ b;
        gen      = a & b;
        chain[0] = ci;
        for (int i = 0; i < GROUP_W; i++) begin
            chain[i+1] = gen[i] | (prop[i] & chain[i]);
        end
        s  = prop ^ chain[GROUP_W-1:0];
        // bypass multiplexer: a fully propagating group hands its carry-in straight on
        co = (&prop) ? ci : chain[GROUP_W];
    end
endmodule

// File: rtl/cskip_adder.sv
module cskip_adder
    import skip_acc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NGRP = W / GROUP_W;

    logic [NGRP:0] carry;

    assign carry[0] = cin;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        cskip_group u_grp (
            .a  (a[g*GROUP_W +: GROUP_W]),
            .b  (b[g*GROUP_W +: GROUP_W]),
            .ci (carry[g]),
            .s  (sum[g*GROUP_W +: GROUP_W]),
            .co (carry[g+1])
        );
    end

    assign cout = carry[NGRP];

    initial begin
        assert_width_R1: assert (W % GROUP_W == 0 && W > 0);
    end

    always_comb begin
        assert_adder_sum_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}));
    end
endmodule

// File: rtl/skip_shift_acc.sv
module skip_shift_acc
    import skip_acc_pkg::*;
#(
    parameter int IN_W      = 10,
    parameter int FRAME_LEN = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      frame_start,
    input  logic [IN_W-1:0]           psum_i,
    output logic                      done_o,
    output logic [IN_W+FRAME_LEN-1:0] result_o
);
    localparam int ACC_W = IN_W + FRAME_LEN;
    localparam int ADD_W = round_up_groups(ACC_W);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] result;
        logic             done;
    } acc_state_t;

    acc_state_t st_d, st_q;

    logic [ADD_W-1:0] add_a_d, add_b_d, add_sum_d;
    logic             add_cout_d;

    // doubled running total plus the zero-extended partial sum
    assign add_a_d = ADD_W'({st_q.acc[ACC_W-2:0], 1'b0});
    assign add_b_d = ADD_W'(psum_i);

    cskip_adder #(.W(ADD_W)) u_add (
        .a    (add_a_d),
        .b    (add_b_d),
        .cin  (1'b0),
        .sum  (add_sum_d),
        .cout (add_cout_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (in_valid) begin
            if (frame_start) begin
                st_d.acc = ACC_W'(psum_i);
                st_d.cnt = CNT_W'(1);
            end else if (st_q.cnt != '0) begin
                st_d.acc = add_sum_d[ACC_W-1:0];
                if (st_q.cnt == CNT_W'(FRAME_LEN - 1)) begin
                    st_d.result = add_sum_d[ACC_W-1:0];
                    st_d.done   = 1'b1;
                    st_d.cnt    = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o   = st_q.done;
    assign result_o = st_q.result;

    initial begin
        assert_frame_len_R5: assert (FRAME_LEN >= 2);
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !frame_start && st_q.cnt != '0) |->
            (!add_cout_d && (add_sum_d >> ACC_W) == '0));

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && frame_start) |=> (st_q.acc == ACC_W'($past(psum_i))));

    assert_idle_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || (!frame_start && st_q.cnt == '0)) |=>
            ($stable(st_q.acc) && $stable(st_q.cnt)));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
endmodule

// File: tb/skip_shift_acc_tb_top.sv
module skip_shift_acc_tb_top;
    localparam int  IN_W     = 10;
    localparam int  FLEN     = 8;
    localparam int  ACC_W    = IN_W + FLEN;
    localparam int  FULL_W   = ((ACC_W + 3) / 4) * 4;
    localparam time CLK_PER  = 10ns;
    localparam int  WDOG_MAX = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic frame_start = 1'b0;
    logic [IN_W-1:0] psum = '0;
    logic done_o;
    logic [ACC_W-1:0] result_o;

    int checks = 0;
    int errors = 0;
    logic [ACC_W-1:0] exp_q[$];
    logic [ACC_W-1:0] prev_result = '0;
    logic prev_done = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    skip_shift_acc #(.IN_W(IN_W), .FRAME_LEN(FLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_start(frame_start),
        .psum_i(psum), .done_o(done_o), .result_o(result_o)
    );

    // adder instances driven directly
    logic [7:0] a8, b8, s8;
    logic c8, co8;
    cskip_adder #(.W(8)) add8_i (.a(a8), .b(b8), .cin(c8), .sum(s8), .cout(co8));

    logic [FULL_W-1:0] aw, bw, sw;
    logic cw, cow;
    cskip_adder #(.W(FULL_W)) addw_i (.a(aw), .b(bw), .cin(cw), .sum(sw), .cout(cow));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic beat(input bit v, input bit s, input logic [IN_W-1:0] d);
        @(posedge clk);
        #1;
        in_valid = v;
        frame_start = s;
        psum = d;
    endtask

    // drives one full frame; gaps inserts idle cycles (R7); pushes the expected total
    task automatic run_frame(input int mode, input bit gaps);
        longint expv = 0;
        for (int k = 0; k < FLEN; k++) begin
            logic [IN_W-1:0] v;
            case (mode)
                0: v = '1;
                1: v = (k == 0) ? IN_W'(1) : '0;
                2: v = IN_W'(k + 1);
                default: v = IN_W'($urandom);
            endcase
            expv = expv * 2 + longint'(v);
            if (k == FLEN - 1) exp_q.push_back(ACC_W'(expv));
            beat(1'b1, k == 0, v);
            if (gaps && ($urandom % 3 == 0)) beat(1'b0, 1'b0, IN_W'($urandom));
        end
        beat(1'b0, 1'b0, '0);
    endtask

    // monitor: scoreboard pop on done; hold and pulse checks otherwise
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done_o) begin
                if (prev_done) check(1'b0, "R5 pulse", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R8 unexpected done", longint'(result_o), 0);
                end else begin
                    logic [ACC_W-1:0] e;
                    e = exp_q.pop_front();
                    check(result_o == e, "R4/R5/R9 frame total", longint'(result_o), longint'(e));
                end
            end else begin
                check(result_o == prev_result, "R6 hold", longint'(result_o), longint'(prev_result));
            end
            prev_done   <= done_o;
            prev_result <= result_o;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG_MAX && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WDOG_MAX);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 exhaustive 8-bit
        for (int ci = 0; ci < 2; ci++) begin
            for (int ia = 0; ia < 256; ia++) begin
                for (int ib = 0; ib < 256; ib++) begin
                    a8 = 8'(ia); b8 = 8'(ib); c8 = 1'(ci);
                    #1;
                    check({co8, s8} == 9'(ia + ib + ci), "R1 8-bit", longint'({co8, s8}), longint'(ia + ib + ci));
                end
            end
        end
        // R2 bypass through a fully propagating group
        a8 = 8'h0F; b8 = 8'h00; c8 = 1'b1; #1;
        check({co8, s8} == 9'h010, "R2 low group bypass", longint'({co8, s8}), 'h10);
        a8 = 8'hA5; b8 = 8'h5A; c8 = 1'b1; #1;
        check({co8, s8} == 9'h100, "R2 both groups bypass", longint'({co8, s8}), 'h100);
        // R1 random full width
        for (int n = 0; n < 300; n++) begin
            longint ex;
            aw = FULL_W'($urandom); bw = FULL_W'($urandom); cw = 1'($urandom);
            #1;
            ex = longint'(aw) + longint'(bw) + longint'(cw);
            check({cow, sw} == (FULL_W+1)'(ex), "R1 full width", longint'({cow, sw}), ex);
        end

        // R10 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done_o == 1'b0, "R10 done", longint'(done_o), 0);
        check(result_o == '0, "R10 result", longint'(result_o), 0);
        @(posedge clk); #1; rst_n = 1'b1;

        run_frame(0, 1'b0);               // R4, R5
        run_frame(1, 1'b0);               // R4 weight of first beat
        run_frame(0, 1'b0);               // R9 all ones max
        begin : max_frame
            longint m = 0;
            for (int k = 0; k < FLEN; k++) begin
                m = m * 2 + ((1 << IN_W) - 1);
                if (k == FLEN - 1) exp_q.push_back(ACC_W'(m));
                beat(1'b1, k == 0, '1);
            end
            beat(1'b0, 1'b0, '0);
        end
        run_frame(2, 1'b1);               // R7 gaps
        // R7 orphan beats while idle
        for (int k = 0; k < 5; k++) beat(1'b1, 1'b0, IN_W'($urandom));
        beat(1'b0, 1'b0, '0);
        repeat (3) @(posedge clk);
        run_frame(2, 1'b0);
        // R8 abort mid-frame, then R3 fresh load
        for (int k = 0; k < 3; k++) beat(1'b1, k == 0, '1);
        run_frame(2, 1'b0);
        // R3 back-to-back frames with stale total
        for (int n = 0; n < 25; n++) run_frame(3, n[0]);

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R5 all results seen", longint'(exp_q.size()), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule